// File: doc/BRIEF.md
# Weighted Two-Source Pixel Mixer

This block blends two 12-bit pixel streams into one 13-bit stream. Each output is a weighted sum in which a 12-bit coefficient sets how much of source A appears, and the rest of the unit weight goes to source B. The sum is then doubled. A coefficient of zero therefore yields twice source B, full weight yields twice source A, and half weight yields the plain sum A + B. The block can be used for fades, cross-dissolves, keyed overlays and frame summing.

The coefficient is unsigned with one integer bit. Any value whose integer bit is set is treated as exactly 1.0. A load enable either captures a new coefficient on each clock or holds the last one, so a static blend needs no coefficient traffic. Both pixel inputs share one format, unsigned or two's complement, chosen per pixel. A flag carrying that format travels down the pipeline beside its own data. The output is the full 13-bit result, without rounding, six clocks after capture.

Top module: `wpix_mixer`

## Requirements
- R1: With `fmt_unsigned` = 1, both sources are read as unsigned 0..4095 and the result is an unsigned 13-bit value, never above 8190.
- R2: With `fmt_unsigned` = 0, both sources are read as two's complement −2048..2047 and the result is a 13-bit two's complement value.
- R3: If bit 11 of the held coefficient is 1, the weight used is exactly 1.0 (2048/2048) and bits 10..0 are ignored, so the output is 2·A.
- R4: Coefficient 0 gives 2·B, and coefficient 0x400 (0.5) gives A + B.
- R5: For a saturated coefficient m in 0..2048, the output equals floor((A·m + B·(2048 − m)) / 1024), kept to its low 13 bits.
- R6: When `coef_load` = 1, `mix_coef` is captured on the rising edge together with the pixels. When it is 0, the previously held coefficient is used and does not change.
- R7: A pixel pair captured at rising edge n appears on `mix_out` after rising edge n+5, so it can be read in the 6th cycle. `mix_out_unsigned` shows that pair's format in the same cycle.
- R8: Synchronous active-high `rst` clears the output, the format flag and the held coefficient. After reset, with no load, the coefficient is 0 and the output is 2·B.
- R9: The two weights always add up to exactly 1.0. Equal sources give 2·A for every coefficient.
- R10: Changing the format select from one cycle to the next affects only the pixel captured with it. Pixels already in the pipeline are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 12 | Source A pixel |
| src_b | input | 12 | Source B pixel |
| mix_coef | input | 12 | Weight of A, unsigned, one integer bit |
| coef_load | input | 1 | 1: capture `mix_coef`; 0: keep the held value |
| fmt_unsigned | input | 1 | Pixel format: 1 unsigned, 0 two's complement |
| mix_out | output | 13 | Doubled weighted sum, unrounded |
| mix_out_unsigned | output | 1 | Format of the pixel now on `mix_out` |

## Verification
Two functions can act in the same cycle: coefficient hold with saturation, and a per-pixel format change. In that cycle a pixel whose format differs from the previous one is mixed with a held coefficient that may sit above 1.0. The random phase provokes this by toggling `coef_load` and `fmt_unsigned` independently on every cycle and by drawing coefficients over the full 12-bit range. The bench judges each such cycle by comparing both `mix_out` and `mix_out_unsigned`, six cycles later, against an arithmetic model. That model tracks the held coefficient on its own.

// File: rtl/wpix_pkg.sv
package wpix_pkg;

    localparam int PIX_W      = 12;
    localparam int MIX_W      = 12;
    localparam int FRAC_W     = MIX_W - 1;
    localparam int EXT_W      = PIX_W + 1;
    localparam int COEF_W     = MIX_W + 1;
    localparam int PROD_W     = EXT_W + COEF_W;
    localparam int SUM_W      = PROD_W + 1;
    localparam int OUT_W      = PIX_W + 1;
    localparam int N_LANES    = 2;
    localparam int PIPE_DEPTH = 6;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [MIX_W-1:0] coef_t;

    localparam coef_t COEF_ONE = {1'b1, {FRAC_W{1'b0}}};

    typedef enum logic {
        FMT_TWOS = 1'b0,
        FMT_UNS  = 1'b1
    } pix_fmt_e;

    // stage 1: raw captured pixels, lane 0 = A, lane 1 = B
    typedef struct packed {
        pix_t [N_LANES-1:0] pix;
        pix_fmt_e           fmt;
    } cap_t;

    // stage 2: widened pixels and their weights
    typedef struct packed {
        logic [N_LANES-1:0][EXT_W-1:0]  pix;
        logic [N_LANES-1:0][COEF_W-1:0] wt;
        pix_fmt_e                       fmt;
    } prep_t;

    // stage 3: full precision products
    typedef struct packed {
        logic [N_LANES-1:0][PROD_W-1:0] prod;
        pix_fmt_e                       fmt;
    } prod_t;

    // stage 4: sum of products
    typedef struct packed {
        logic [SUM_W-1:0] sum;
        pix_fmt_e         fmt;
    } sum_t;

    // stages 5 and 6: doubled, truncated result
    typedef struct packed {
        logic [OUT_W-1:0] data;
        pix_fmt_e         fmt;
    } res_t;

    function automatic coef_t clamp_coef(coef_t m);
        return m[MIX_W-1] ? COEF_ONE : m;
    endfunction

    function automatic logic [EXT_W-1:0] widen_pix(pix_t p, pix_fmt_e f);
        return (f == FMT_UNS) ? {1'b0, p} : {p[PIX_W-1], p};
    endfunction

endpackage

// File: rtl/wpix_capture.sv
module wpix_capture
    import wpix_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pix_t     a_in,
    input  pix_t     b_in,
    input  coef_t    coef_in,
    input  logic     coef_en,
    input  pix_fmt_e fmt_in,
    output cap_t     cap_q,
    output coef_t    coef_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            coef_q <= '0;
        end else begin
            cap_q.pix[0] <= a_in;
            cap_q.pix[1] <= b_in;
            cap_q.fmt    <= fmt_in;
            if (coef_en) begin
                coef_q <= coef_in;
            end
        end
    end

endmodule

// File: rtl/wpix_weight.sv
module wpix_weight
    import wpix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cap_t  cap_q,
    input  coef_t coef_q,
    output prep_t prep_q
);

    coef_t sat;
    prep_t prep_d;

    always_comb begin
        sat       = clamp_coef(coef_q);
        prep_d.wt[0] = {1'b0, sat};
        prep_d.wt[1] = {1'b0, COEF_ONE} - {1'b0, sat};
        prep_d.fmt   = cap_q.fmt;
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_widen
        assign prep_d.pix[i] = widen_pix(cap_q.pix[i], cap_q.fmt);
    end

    always_ff @(posedge clk) begin
        if (rst) prep_q <= '0;
        else     prep_q <= prep_d;
    end

endmodule

// File: rtl/wpix_product.sv
module wpix_product
    import wpix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prep_t prep_q,
    output prod_t prod_q
);

    logic [N_LANES-1:0][PROD_W-1:0] prod_d;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic signed [PROD_W-1:0] p;
        assign p         = $signed(prep_q.pix[i]) * $signed(prep_q.wt[i]);
        assign prod_d[i] = p;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q.prod <= prod_d;
            prod_q.fmt  <= prep_q.fmt;
        end
    end

endmodule

// File: rtl/wpix_combine.sv
module wpix_combine
    import wpix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prod_t prod_q,
    output res_t  out_q
);

    logic signed [SUM_W-1:0] sum_d;
    logic        [SUM_W:0]   dbl;
    sum_t sum_q;
    res_t shift_q;

    assign sum_d = $signed(prod_q.prod[0]) + $signed(prod_q.prod[1]);
    // fixed doubling, then drop the fractional weight bits
    assign dbl   = {sum_q.sum, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            shift_q <= '0;
            out_q   <= '0;
        end else begin
            sum_q.sum    <= sum_d;
            sum_q.fmt    <= prod_q.fmt;
            shift_q.data <= dbl[FRAC_W+OUT_W-1:FRAC_W];
            shift_q.fmt  <= sum_q.fmt;
            out_q        <= shift_q;
        end
    end

endmodule

// File: rtl/wpix_mixer.sv
module wpix_mixer
    import wpix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] src_a,
    input  logic [11:0] src_b,
    input  logic [11:0] mix_coef,
    input  logic        coef_load,
    input  logic        fmt_unsigned,
    output logic [12:0] mix_out,
    output logic        mix_out_unsigned
);

    cap_t  cap_q;
    coef_t coef_q;
    prep_t prep_q;
    prod_t prod_q;
    res_t  out_q;
    pix_fmt_e fmt_sel;

    assign fmt_sel = fmt_unsigned ? FMT_UNS : FMT_TWOS;

    wpix_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .a_in    (src_a),
        .b_in    (src_b),
        .coef_in (mix_coef),
        .coef_en (coef_load),
        .fmt_in  (fmt_sel),
        .cap_q   (cap_q),
        .coef_q  (coef_q)
    );

    wpix_weight u_weight (
        .clk    (clk),
        .rst    (rst),
        .cap_q  (cap_q),
        .coef_q (coef_q),
        .prep_q (prep_q)
    );

    wpix_product u_product (
        .clk    (clk),
        .rst    (rst),
        .prep_q (prep_q),
        .prod_q (prod_q)
    );

    wpix_combine u_combine (
        .clk    (clk),
        .rst    (rst),
        .prod_q (prod_q),
        .out_q  (out_q)
    );

    assign mix_out          = out_q.data;
    assign mix_out_unsigned = (out_q.fmt == FMT_UNS);

endmodule

// File: rtl/wpix_checker.sv
module wpix_checker
    import wpix_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [11:0] mix_coef,
    input logic        coef_load,
    input logic        fmt_unsigned,
    input coef_t       coef_q,
    input prep_t       prep_q,
    input logic [12:0] mix_out,
    input logic        mix_out_unsigned
);

    logic [2:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    // R6: held coefficient does not move without a load
    p_coef_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !coef_load |=> $stable(coef_q));

    // R6: a load captures the presented coefficient
    p_coef_take_r6: assert property (@(posedge clk) disable iff (rst)
        coef_load |=> coef_q == $past(mix_coef));

    // R3: integer bit set forces the A weight to exactly one
    p_sat_one_r3: assert property (@(posedge clk) disable iff (rst)
        coef_q[MIX_W-1] |=> prep_q.wt[0] == {1'b0, COEF_ONE});

    // R9: weights are complementary
    p_weight_sum_r9: assert property (@(posedge clk) disable iff (rst)
        warm >= 3'd2 |-> (prep_q.wt[0] + prep_q.wt[1]) == {1'b0, COEF_ONE});

    // R7: format flag leaves six cycles after its pixel entered
    p_fmt_align_r7: assert property (@(posedge clk) disable iff (rst)
        warm >= 3'd6 |-> mix_out_unsigned == $past(fmt_unsigned, 6));

    // R1: unsigned results stay below the all-ones code
    p_uns_range_r1: assert property (@(posedge clk) disable iff (rst)
        mix_out_unsigned |-> mix_out != 13'h1FFF);

    // R8: reset clears the visible outputs
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (mix_out == '0) && !mix_out_unsigned);

endmodule

bind wpix_mixer wpix_checker u_checker (
    .clk              (clk),
    .rst              (rst),
    .mix_coef         (mix_coef),
    .coef_load        (coef_load),
    .fmt_unsigned     (fmt_unsigned),
    .coef_q           (coef_q),
    .prep_q           (prep_q),
    .mix_out          (mix_out),
    .mix_out_unsigned (mix_out_unsigned)
);

// File: tb/test_wpix_mixer.sv
`timescale 1ns/1ps
module test_wpix_mixer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] src_a = '0, src_b = '0, mix_coef = '0;
    logic        coef_load = 1'b0, fmt_unsigned = 1'b0;
    logic [12:0] mix_out;
    logic        mix_out_unsigned;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wpix_mixer i_wpix_mixer (
        .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
        .mix_coef(mix_coef), .coef_load(coef_load), .fmt_unsigned(fmt_unsigned),
        .mix_out(mix_out), .mix_out_unsigned(mix_out_unsigned)
    );

    // expectation ring, six entries in flight
    logic [12:0] exp_d [8];
    logic        exp_f [8];
    string       tag_d [8];
    string       tag_f [8];
    int          n_steps = 0;
    logic [11:0] m_model = '0;
    logic        prev_fmt = 1'b0;

    function automatic logic [12:0] model(logic [11:0] a, logic [11:0] b,
                                          logic [11:0] m, logic u);
        longint av, bv, ms, s, r;
        av = u ? longint'(a) : longint'($signed(a));
        bv = u ? longint'(b) : longint'($signed(b));
        ms = m[11] ? 64'sd2048 : longint'(m);
        s  = av * ms + bv * (64'sd2048 - ms);
        r  = s >>> 10;
        return r[12:0];
    endfunction

    task automatic check(string req, logic [12:0] act, logic [12:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // called at a falling edge: check the oldest entry, then drive new inputs
    task automatic step(logic [11:0] a, logic [11:0] b, logic [11:0] m,
                        logic en, logic u, string tdata);
        int slot;
        if (n_steps >= 6) begin
            slot = (n_steps - 6) % 8;
            check(tag_d[slot], mix_out, exp_d[slot]);
            check(tag_f[slot], {12'd0, mix_out_unsigned}, {12'd0, exp_f[slot]});
        end
        src_a = a; src_b = b; mix_coef = m; coef_load = en; fmt_unsigned = u;
        if (en) m_model = m;
        slot = n_steps % 8;
        exp_d[slot] = model(a, b, m_model, u);
        exp_f[slot] = u;
        tag_d[slot] = tdata;
        tag_f[slot] = (u != prev_fmt) ? "R10" : "R7";
        prev_fmt = u;
        n_steps++;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [11:0] pick(int k);
        case (k)
            0: return 12'h000; 1: return 12'h001; 2: return 12'h7FF;
            3: return 12'h800; 4: return 12'hFFF; 5: return 12'h555;
            6: return 12'hAAA; default: return 12'h123;
        endcase
    endfunction

    function automatic logic [11:0] pick_m(int k);
        case (k)
            0: return 12'h000; 1: return 12'h001; 2: return 12'h400;
            3: return 12'h7FF; 4: return 12'h800; 5: return 12'h801;
            6: return 12'hC00; 7: return 12'hFFF; 8: return 12'h2AB;
            default: return 12'h600;
        endcase
    endfunction

    initial begin
        src_a = 12'h3C3; src_b = 12'h5A5; mix_coef = 12'h7AB;
        coef_load = 1'b1; fmt_unsigned = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: outputs cleared under reset
        check("R8", mix_out, 13'd0);
        check("R8", {12'd0, mix_out_unsigned}, 13'd0);
        rst = 1'b0;
        prev_fmt = 1'b1;
        // R8: coefficient cleared, no load yet -> 2*B
        for (int i = 0; i < 6; i++)
            step(12'($urandom), 12'($urandom), 12'hFFF, 1'b0, 1'(i & 1), "R8");

        // corner sweep, both formats
        for (int u = 0; u < 2; u++)
            for (int ia = 0; ia < 8; ia++)
                for (int ib = 0; ib < 8; ib++)
                    for (int im = 0; im < 10; im++) begin
                        logic [11:0] m;
                        string t;
                        m = pick_m(im);
                        if (m[11])                        t = "R3";
                        else if (m == 12'h000 || m == 12'h400) t = "R4";
                        else if (u == 1)                  t = "R1";
                        else                              t = "R2";
                        step(pick(ia), pick(ib), m, 1'b1, 1'(u), t);
                    end

        // R9: equal sources, any coefficient
        for (int i = 0; i < 400; i++) begin
            logic [11:0] v;
            v = 12'($urandom);
            step(v, v, 12'($urandom), 1'b1, 1'($urandom), "R9");
        end

        // random mix with hold and per-cycle format changes (R5, R6, R10)
        for (int i = 0; i < 4000; i++) begin
            logic en;
            en = ($urandom % 3) != 0;
            step(12'($urandom), 12'($urandom), 12'($urandom), en,
                 1'($urandom), en ? "R5" : "R6");
        end

        // drain the pipeline so the last entries are checked
        for (int i = 0; i < 6; i++)
            step(12'd0, 12'd0, 12'd0, 1'b0, 1'b0, "R7");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule